// File: doc/BRIEF.md
# Bit-Masked Write Memory (Two-Phase Read-Merge-Commit)

This block provides a word-addressed memory in which every bit of a write can be individually enabled, even though the storage array underneath only accepts whole-word writes. It runs on a fast clock at twice the system rate. Each system cycle is split into two fast cycles: a capture phase and a commit phase. In the capture phase a write request is latched and the stored word at the target address is fetched through the array's second port. In the commit phase each bit of the new word is taken from the request data where the mask bit is 1 and from the fetched word where it is 0, and the merged word is written back.

The array's second port is time-shared. It fetches the word to be merged during capture and serves the external read during commit. That read happens on the same edge as the commit write, so it returns the word as it was before that write. The read result appears on `rd_data` at the next capture edge and is held for the whole following system cycle. The `busy` output is high during the commit phase. A write request is only sampled while `busy` is low, so one write can be accepted every system cycle.

The controller has two named states. `PH_CAPTURE` always moves to `PH_COMMIT` on the next fast edge, through the transition *latch*. `PH_COMMIT` always returns to `PH_CAPTURE`, through the transition *commit*. Reset enters `PH_CAPTURE`.

Top module: `bitmask_rmw_mem`

## Requirements
- R1: After reset the controller is in `PH_CAPTURE`, `busy` is 0 and `rd_data` is 0.
- R2: The phase alternates on every fast clock edge. `busy` is 0 in `PH_CAPTURE` and 1 in `PH_COMMIT`.
- R3: A write accepted at a capture edge is committed at the very next fast edge, to the address sampled at capture. The merge source is the word fetched from that same address at the capture edge.
- R4: For a committed write, stored bit i equals `wr_data[i]` where `wr_mask[i]` is 1, and keeps its previous value where `wr_mask[i]` is 0. This holds for every address and every mask value.
- R5: A mask of all ones stores `wr_data` unchanged.
- R6: A mask of all zeros leaves the stored word unchanged.
- R7: A read of address A in the same system cycle as a write to A returns the word from before the write. A read in a later system cycle returns the merged word.
- R8: `wr_req` and the other write inputs are ignored while `busy` is 1. A request presented then changes no stored word.
- R9: Writes may be issued in consecutive system cycles. A second write to the same address merges onto the result of the first.
- R10: `rd_data` changes only at capture edges. It holds the word read at `rd_addr` in the previous system cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Fast clock, twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled at capture edges |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | New write data |
| wr_mask | input | DW | Per-bit write enable, 1 = take the new bit |
| rd_addr | input | AW | Read word address, sampled at capture edges |
| rd_data | output | DW | Read word, valid from the next capture edge |
| busy | output | 1 | High in the commit phase; write inputs are ignored then |

## Verification
The assertions check the following on every fast cycle:
- the strict alternation of the two phases;
- that a commit write lands on the address fetched at the preceding capture;
- that all-ones and all-zeros masks reduce the merge to a plain copy;
- that `rd_data` never moves at a commit edge.

Only the bench's scenarios can show the stored contents against a reference model. The bench sweeps every mask value at every address and checks the read-before-write ordering when a read and a write target the same word. It also checks that a request raised during the commit phase leaves memory untouched.

// File: rtl/bmrmw_pkg.sv
package bmrmw_pkg;
    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_COMMIT  = 1'b1
    } phase_e;
endpackage

// File: rtl/bmrmw_phase_fsm.sv
module bmrmw_phase_fsm
    import bmrmw_pkg::*;
(
    input  logic   clk2x,
    input  logic   rst_n,
    output phase_e phase,
    output logic   busy,
    output logic   capture_en
);
    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_CAPTURE: phase_d = PH_COMMIT;   // latch
            PH_COMMIT:  phase_d = PH_CAPTURE;  // commit
        endcase
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_CAPTURE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        busy       = 1'b0;
        capture_en = 1'b0;
        unique case (phase_q)
            PH_CAPTURE: capture_en = 1'b1;
            PH_COMMIT:  busy       = 1'b1;
        endcase
    end

    assign phase = phase_q;

    a_r2_capture_to_commit: assert property (@(posedge clk2x) disable iff (!rst_n)
        (phase_q == PH_CAPTURE) |=> (phase_q == PH_COMMIT));
    a_r2_commit_to_capture: assert property (@(posedge clk2x) disable iff (!rst_n)
        (phase_q == PH_COMMIT) |=> (phase_q == PH_CAPTURE));
endmodule

// File: rtl/bmrmw_merge.sv
module bmrmw_merge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] new_word,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] bit_en,
    output logic [DW-1:0] merged
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign merged[i] = bit_en[i] ? new_word[i] : old_word[i];
    end
endmodule

// File: rtl/bmrmw_array.sv
module bmrmw_array #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk2x,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk2x) begin
        if (wa_en) mem[wa_addr] <= wa_data;
        rb_q <= mem[rb_addr];
    end
endmodule

// File: rtl/bitmask_rmw_mem.sv
module bitmask_rmw_mem
    import bmrmw_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] wr_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    phase_e        phase;
    logic          capture_en;
    logic          p_valid;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;
    logic [DW-1:0] p_mask;
    logic [AW-1:0] p_raddr;
    logic [AW-1:0] rb_addr;
    logic [DW-1:0] rb_q;
    logic [DW-1:0] merged;
    logic          mem_we;

    bmrmw_phase_fsm u_fsm (
        .clk2x      (clk2x),
        .rst_n      (rst_n),
        .phase      (phase),
        .busy       (busy),
        .capture_en (capture_en)
    );

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_addr  <= '0;
            p_data  <= '0;
            p_mask  <= '0;
            p_raddr <= '0;
            rd_data <= '0;
        end else if (capture_en) begin
            p_valid <= wr_req;
            p_addr  <= wr_addr;
            p_data  <= wr_data;
            p_mask  <= wr_mask;
            p_raddr <= rd_addr;
            rd_data <= rb_q;
        end
    end

    // Second port: fetch-for-merge in capture, external read in commit
    assign rb_addr = capture_en ? wr_addr : p_raddr;
    assign mem_we  = (phase == PH_COMMIT) && p_valid;

    bmrmw_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
        .clk2x   (clk2x),
        .wa_en   (mem_we),
        .wa_addr (p_addr),
        .wa_data (merged),
        .rb_addr (rb_addr),
        .rb_q    (rb_q)
    );

    bmrmw_merge #(.DW(DW)) u_merge (
        .new_word (p_data),
        .old_word (rb_q),
        .bit_en   (p_mask),
        .merged   (merged)
    );

    a_r3_commit_addr_matches_fetch: assert property (@(posedge clk2x) disable iff (!rst_n)
        mem_we |-> (p_addr == $past(rb_addr)));
    a_r3_commit_follows_request: assert property (@(posedge clk2x) disable iff (!rst_n)
        mem_we |-> $past(wr_req && !busy));
    a_r5_full_mask_copies: assert property (@(posedge clk2x) disable iff (!rst_n)
        (mem_we && (&p_mask)) |-> (merged == p_data));
    a_r6_empty_mask_keeps: assert property (@(posedge clk2x) disable iff (!rst_n)
        (mem_we && (p_mask == '0)) |-> (merged == rb_q));
    a_r8_hold_during_commit: assert property (@(posedge clk2x) disable iff (!rst_n)
        busy |=> ($stable(p_addr) && $stable(p_data) && $stable(p_mask)));
    a_r10_rd_data_still_at_commit: assert property (@(posedge clk2x) disable iff (!rst_n)
        busy |=> $stable(rd_data));
endmodule

// File: tb/bitmask_rmw_mem_tb_top.sv
module bitmask_rmw_mem_tb_top;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int AW    = 3;

    logic          clk2x = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] wr_mask = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] got;
    logic [DW-1:0] expv;
    logic          done = 1'b0;

    always #4 clk2x = ~clk2x;

    bitmask_rmw_mem #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk2x(clk2x), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // One system cycle; prev_rd returns rd_data after this cycle's capture edge,
    // i.e. the read issued in the previous system cycle (R10).
    task automatic sys_cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [DW-1:0] m, input logic [AW-1:0] ra,
                           input logic inject, output logic [DW-1:0] prev_rd);
        wr_req = we; wr_addr = a; wr_data = d; wr_mask = m; rd_addr = ra;
        @(posedge clk2x);
        @(negedge clk2x);
        prev_rd = rd_data;
        if (inject) begin
            wr_req = 1'b1; wr_addr = a; wr_data = ~d; wr_mask = '1;
        end else begin
            wr_req = 1'b0;
        end
        @(posedge clk2x);
        @(negedge clk2x);
        wr_req = 1'b0;
        if (we) for (int i = 0; i < DW; i++) if (m[i]) ref_mem[a][i] = d[i];
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v);
        logic [DW-1:0] dummy;
        sys_cyc(1'b0, '0, '0, '0, a, 1'b0, dummy);
        sys_cyc(1'b0, '0, '0, '0, a, 1'b0, v);
    endtask

    initial begin
        repeat (3) @(negedge clk2x);
        // R1: reset state
        check("R1 busy", {7'b0, busy}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk2x);
        // R2: after the first edge the controller is in commit
        check("R2 busy high", {7'b0, busy}, 8'h01);
        @(negedge clk2x);
        check("R2 busy low", {7'b0, busy}, 8'h00);

        // R5: initialise every word with a full mask
        for (int a = 0; a < DEPTH; a++)
            sys_cyc(1'b1, a[AW-1:0], 8'(a * 29 + 7), '1, '0, 1'b0, got);
        for (int a = 0; a < DEPTH; a++) begin
            read_word(a[AW-1:0], got);
            check("R5 full mask", got, 8'(a * 29 + 7));
        end

        // R4: every mask at every address
        for (int a = 0; a < DEPTH; a++)
            for (int m = 0; m < 256; m++) begin
                sys_cyc(1'b1, a[AW-1:0], 8'((a * 37 + m * 11) ^ 8'h5A), 8'(m), a[AW-1:0], 1'b0, got);
                sys_cyc(1'b0, '0, '0, '0, a[AW-1:0], 1'b0, got);
                expv = ref_mem[a];
                sys_cyc(1'b0, '0, '0, '0, '0, 1'b0, got);
                check("R4 masked merge", got, expv);
            end

        // R6: zero mask leaves the word
        expv = ref_mem[3];
        sys_cyc(1'b1, 3'd3, 8'hFF ^ expv, 8'h00, '0, 1'b0, got);
        read_word(3'd3, got);
        check("R6 zero mask", got, expv);

        // R7: same-cycle read returns old data, then new
        sys_cyc(1'b1, 3'd2, 8'hC3, '1, '0, 1'b0, got);
        sys_cyc(1'b1, 3'd2, 8'h3C, '1, 3'd2, 1'b0, got);
        sys_cyc(1'b0, '0, '0, '0, 3'd2, 1'b0, got);
        check("R7 pre-write read", got, 8'hC3);
        sys_cyc(1'b0, '0, '0, '0, '0, 1'b0, got);
        check("R7 later read", got, 8'h3C);

        // R9: back-to-back writes to one word merge in order
        sys_cyc(1'b1, 3'd5, 8'h00, '1, '0, 1'b0, got);
        sys_cyc(1'b1, 3'd5, 8'hFF, 8'h0F, '0, 1'b0, got);
        sys_cyc(1'b1, 3'd5, 8'hA0, 8'hF0, '0, 1'b0, got);
        sys_cyc(1'b1, 3'd5, 8'h00, 8'h81, '0, 1'b0, got);
        read_word(3'd5, got);
        check("R9 back-to-back", got, 8'h2E);
        check("R9 model", ref_mem[5], 8'h2E);

        // R8: request raised during commit is ignored
        sys_cyc(1'b1, 3'd6, 8'h55, '1, '0, 1'b0, got);
        sys_cyc(1'b0, 3'd6, 8'h12, '0, '0, 1'b1, got);
        read_word(3'd6, got);
        check("R8 commit-phase request", got, 8'h55);
        sys_cyc(1'b0, 3'd1, 8'h99, '0, '0, 1'b1, got);
        read_word(3'd1, got);
        check("R8 other address", got, ref_mem[1]);

        // R10: rd_data holds across the commit edge
        sys_cyc(1'b0, '0, '0, '0, 3'd6, 1'b0, got);
        wr_req = 1'b0; rd_addr = 3'd1;
        @(posedge clk2x);
        @(negedge clk2x);
        expv = rd_data;
        check("R10 capture update", expv, 8'h55);
        @(posedge clk2x);
        @(negedge clk2x);
        check("R10 hold at commit", rd_data, expv);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk2x);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule